// File: doc/BRIEF.md
# Two-Lane Serial Sample Emitter

This block is the transmit end of a source-synchronous link with two data lanes, a frame-marker lane and a bit clock lane. It takes 16-bit samples from a ready/valid source, grouped into bursts, where each burst holds the samples of one chirp. Samples are paired: the first of each pair goes out on lane 0 and the second on lane 1, most significant bit first. The frame marker goes through one full period for each pair.

The block runs at bit-clock rate under a clock enable `bitEn`. Each enabled cycle stands for one full period of the outgoing bit clock, and each lane output carries two half-period values per cycle: `[1]` follows the rising edge and `[0]` the falling edge. In double data rate mode each half carries its own bit. In single data rate mode one bit fills both halves, so every frame takes twice as many cycles. The sample width (12, 14 or 16 bits) and the rate mode are sampled at the start of each burst. A narrow width sends the upper bits of the 16-bit input and drops the rest. Between bursts the clock lane keeps running while the data and marker lanes hold still.

Top module: `sampleStreamTx`

## Requirements
- R1: After reset the clock lane `clkBits` is 2'b10 in every cycle, whether idle or busy. During reset it is 2'b00.
- R2: A frame lasts W/2 enabled cycles in double rate mode and W cycles in single rate mode. W is 12 when `widthSel` is 0, 14 when it is 1, and 16 when it is 2 or 3. The marker `frmBits` is high for frame bit times 0 to W/2-1 and low for the rest, so in double rate with W=14 the middle cycle shows 2'b10.
- R3: Frame bit time k of a lane carries bit 15-k of that lane's 16-bit sample, for k from 0 to W-1. The lower 16-W bits never appear.
- R4: Accepted samples alternate between lanes, starting at lane 0 for each burst. If a burst has an odd number of samples, lane 1 of its last frame carries all zeros.
- R5: `ddrMode`=1 selects double rate, where frame bit times 2c and 2c+1 appear in `[1]` and `[0]` of cycle c. `ddrMode`=0 selects single rate, where bit time c appears in both halves of cycle c.
- R6: In an enabled cycle with no frame in progress, the data lanes hold their last value and the marker stays at 2'b00.
- R7: `sampleReady` is low exactly while a complete pair is waiting. A waiting pair starts on the cycle after the previous frame's last cycle, with no gap. From idle, a frame starts one enabled cycle after its pair becomes complete.
- R8: `widthSel` and `ddrMode` are sampled only when the first frame of a burst is loaded. Changes made during a burst have no effect until the next burst.
- R9: In a cycle with `bitEn` low, no lane output changes and frame progress does not advance. Sample intake continues.
- R10: During reset all lane outputs are zero and `sampleReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| bitEn | input | 1 | Enable: one bit-clock period per enabled cycle |
| ddrMode | input | 1 | 1 double data rate, 0 single data rate |
| widthSel | input | 2 | Sample width: 0 is 12, 1 is 14, otherwise 16 |
| sampleData | input | 16 | Incoming sample |
| sampleValid | input | 1 | Sample present |
| sampleLast | input | 1 | Sample ends the burst |
| sampleReady | output | 1 | Block accepts a sample |
| lane0Bits | output | 2 | Lane 0, rising then falling half |
| lane1Bits | output | 2 | Lane 1, rising then falling half |
| frmBits | output | 2 | Frame marker lane, both halves |
| clkBits | output | 2 | Bit clock lane, both halves |

## Verification
Two things can happen in the same cycle: the last frame of one burst ends, and the first pair of the next burst is loaded, which also re-samples the width and rate settings. The bench sends bursts back to back. It changes `widthSel` and `ddrMode` while the next pair is waiting, so that the reload and the setting capture fall on the same edge. A behavioural model built on queues predicts every lane half-bit, the marker, the clock lane and `sampleReady` for every cycle. The check passes only if the new frame starts with no gap and has the new length.

// File: rtl/ssePkg.sv
package ssePkg;
  localparam int SMP_W  = 16;
  localparam int LANES  = 2;
  localparam int W_LO   = 12;
  localparam int W_MID  = 14;
  localparam int BIT_W  = $clog2(SMP_W);
  localparam int IDX_W  = $clog2(SMP_W + 1);

  typedef struct packed {
    logic             captA;
    logic             captB;
    logic             padB;
    logic             loadFrame;
    logic             emit;
    logic [BIT_W-1:0] cycIdx;
    logic             ddr;
    logic [IDX_W-1:0] widthBits;
  } sseStrobe_t;
endpackage

// File: rtl/sseCtrl.sv
module sseCtrl
  import ssePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bitEn,
  input  logic        sampleValid,
  input  logic        sampleLast,
  input  logic        ddrMode,
  input  logic [1:0]  widthSel,
  output logic        sampleReady,
  output sseStrobe_t  strb
);
  logic             haveA, pairFull, pairLast;
  logic             active, inBurst, frameLast;
  logic [BIT_W-1:0] cnt, cyclesM1;
  logic             cfgDdr;
  logic [IDX_W-1:0] cfgW, reqW;
  logic             accept, captA, captB, padB;
  logic             frameEnd, loadFrame, newBurst, emit;

  always_comb begin
    case (widthSel)
      2'd0:    reqW = IDX_W'(W_LO);
      2'd1:    reqW = IDX_W'(W_MID);
      default: reqW = IDX_W'(SMP_W);
    endcase
  end

  assign accept    = sampleValid && !pairFull;
  assign captA     = accept && !haveA;
  assign captB     = accept && haveA;
  assign padB      = captA && sampleLast;
  assign cyclesM1  = cfgDdr ? BIT_W'((cfgW >> 1) - IDX_W'(1)) : BIT_W'(cfgW - IDX_W'(1));
  assign emit      = bitEn && active;
  assign frameEnd  = emit && (cnt == cyclesM1);
  assign loadFrame = bitEn && pairFull && (!active || frameEnd);
  assign newBurst  = !inBurst || (frameEnd && frameLast);
  assign sampleReady = !pairFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveA     <= 1'b0;
      pairFull  <= 1'b0;
      pairLast  <= 1'b0;
      active    <= 1'b0;
      inBurst   <= 1'b0;
      frameLast <= 1'b0;
      cnt       <= '0;
      cfgDdr    <= 1'b1;
      cfgW      <= IDX_W'(SMP_W);
    end else begin
      if (captA && !sampleLast) haveA <= 1'b1;
      else if (captB)           haveA <= 1'b0;

      if (loadFrame)           pairFull <= 1'b0;
      else if (captB || padB)  pairFull <= 1'b1;

      if (padB)       pairLast <= 1'b1;
      else if (captB) pairLast <= sampleLast;

      if (loadFrame) begin
        active    <= 1'b1;
        inBurst   <= 1'b1;
        cnt       <= '0;
        frameLast <= pairLast;
        if (newBurst) begin
          cfgDdr <= ddrMode;
          cfgW   <= reqW;
        end
      end else begin
        if (frameEnd) begin
          active <= 1'b0;
          if (frameLast) inBurst <= 1'b0;
        end
        if (emit) cnt <= cnt + BIT_W'(1);
      end
    end
  end

  always_comb begin
    strb           = '0;
    strb.captA     = captA;
    strb.captB     = captB;
    strb.padB      = padB;
    strb.loadFrame = loadFrame;
    strb.emit      = emit;
    strb.cycIdx    = cnt;
    strb.ddr       = cfgDdr;
    strb.widthBits = cfgW;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt <= cyclesM1)); // R2
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && cnt != '0) |-> ($stable(cfgW) && $stable(cfgDdr))); // R8
  AST_PAIR_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && sampleReady && haveA) |=> pairFull); // R7
  AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> ($stable(cnt) && $stable(active))); // R9
endmodule

// File: rtl/sseData.sv
module sseData
  import ssePkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SMP_W-1:0]             sampleData,
  input  sseStrobe_t                   strb,
  output logic [LANES-1:0][1:0]        laneBits,
  output logic [1:0]                   frmBits,
  output logic [1:0]                   clkBits
);
  logic [LANES-1:0][SMP_W-1:0] pairWord, frameWord;
  logic [BIT_W-1:0]            k0, k1, idx0, idx1;
  logic [IDX_W-1:0]            halfW;
  logic [LANES-1:0][1:0]       nextBits;

  assign k0    = strb.ddr ? {strb.cycIdx[BIT_W-2:0], 1'b0} : strb.cycIdx;
  assign k1    = strb.ddr ? (k0 | BIT_W'(1)) : k0;
  assign idx0  = BIT_W'(SMP_W - 1) - k0;
  assign idx1  = BIT_W'(SMP_W - 1) - k1;
  assign halfW = strb.widthBits >> 1;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_laneSel
    assign nextBits[ln] = {frameWord[ln][idx0], frameWord[ln][idx1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pairWord  <= '0;
      frameWord <= '0;
      laneBits  <= '0;
      frmBits   <= 2'b00;
      clkBits   <= 2'b00;
    end else begin
      clkBits <= 2'b10;
      if (strb.captA) pairWord[0] <= sampleData;
      if (strb.captB) pairWord[1] <= sampleData;
      else if (strb.padB) pairWord[1] <= '0;
      if (strb.emit) begin
        laneBits <= nextBits;
        frmBits  <= {IDX_W'(k0) < halfW, IDX_W'(k1) < halfW};
      end
      if (strb.loadFrame) frameWord <= pairWord;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.emit |=> ($stable(laneBits) && $stable(frmBits))); // R6
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    strb.padB |=> (pairWord[1] == '0)); // R4
  AST_CLK_RUNS: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (clkBits == 2'b10)); // R1
endmodule

// File: rtl/sampleStreamTx.sv
module sampleStreamTx
  import ssePkg::*;
#(
  parameter int SAMPLE_W = SMP_W
)(
  input  logic                clk,
  input  logic                rst,
  input  logic                bitEn,
  input  logic                ddrMode,
  input  logic [1:0]          widthSel,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  input  logic                sampleLast,
  output logic                sampleReady,
  output logic [1:0]          lane0Bits,
  output logic [1:0]          lane1Bits,
  output logic [1:0]          frmBits,
  output logic [1:0]          clkBits
);
  sseStrobe_t            strb;
  logic [LANES-1:0][1:0] laneBits;

  sseCtrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .bitEn       (bitEn),
    .sampleValid (sampleValid),
    .sampleLast  (sampleLast),
    .ddrMode     (ddrMode),
    .widthSel    (widthSel),
    .sampleReady (sampleReady),
    .strb        (strb)
  );

  sseData u_data (
    .clk        (clk),
    .rst        (rst),
    .sampleData (SMP_W'(sampleData)),
    .strb       (strb),
    .laneBits   (laneBits),
    .frmBits    (frmBits),
    .clkBits    (clkBits)
  );

  assign lane0Bits = laneBits[0];
  assign lane1Bits = laneBits[1];
endmodule

// File: tb/sampleStreamTx_bench.sv
module sampleStreamTx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bitEn = 1'b1;
  logic        ddrMode = 1'b1;
  logic [1:0]  widthSel = 2'd2;
  logic [15:0] sampleData = '0;
  logic        sampleValid = 1'b0;
  logic        sampleLast = 1'b0;
  logic        sampleReady;
  logic [1:0]  lane0Bits, lane1Bits, frmBits, clkBits;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    gapMode = 0;
  string phaseTag = "R10";

  always #2 clk = ~clk;

  sampleStreamTx u_sampleStreamTx (
    .clk(clk), .rst(rst), .bitEn(bitEn), .ddrMode(ddrMode), .widthSel(widthSel),
    .sampleData(sampleData), .sampleValid(sampleValid), .sampleLast(sampleLast),
    .sampleReady(sampleReady), .lane0Bits(lane0Bits), .lane1Bits(lane1Bits),
    .frmBits(frmBits), .clkBits(clkBits)
  );

  // behavioural reference model
  bit          mHaveA, mFull, mPL, mActive, mInBurst, mFL, mDdr;
  logic [15:0] mQ[$];
  logic [15:0] mFA, mFB;
  int          mCnt, mW;
  logic [1:0]  mL0, mL1, mFrm, mClk;

  function automatic int widthOf(logic [1:0] s);
    return (s == 2'd0) ? 12 : (s == 2'd1) ? 14 : 16;
  endfunction

  always @(posedge clk) begin
    bit acc, finish;
    int kA, kB, cyc;
    if (rst) begin
      mHaveA = 0; mFull = 0; mPL = 0; mActive = 0; mInBurst = 0; mFL = 0;
      mDdr = 1; mW = 16; mCnt = 0; mFA = '0; mFB = '0; mQ.delete();
      mL0 = '0; mL1 = '0; mFrm = '0; mClk = '0;
    end else begin
      mClk = 2'b10;
      acc = sampleValid && !mFull;
      finish = 0;
      if (bitEn) begin
        if (mActive) begin
          kA = mDdr ? 2 * mCnt : mCnt;
          kB = mDdr ? 2 * mCnt + 1 : mCnt;
          mL0  = {mFA[15 - kA], mFA[15 - kB]};
          mL1  = {mFB[15 - kA], mFB[15 - kB]};
          mFrm = {kA < mW / 2, kB < mW / 2};
          cyc = mDdr ? mW / 2 : mW;
          if (mCnt == cyc - 1) finish = 1;
          else mCnt++;
        end
        if (mFull && (!mActive || finish)) begin
          if (!mInBurst || (finish && mFL)) begin
            mW = widthOf(widthSel);
            mDdr = ddrMode;
          end
          mFA = mQ.pop_front();
          mFB = mQ.pop_front();
          mFL = mPL; mFull = 0; mActive = 1; mCnt = 0; mInBurst = 1;
        end else if (finish) begin
          mActive = 0;
          if (mFL) mInBurst = 0;
        end
      end
      if (acc) begin
        mQ.push_back(sampleData);
        if (!mHaveA) begin
          if (sampleLast) begin
            mQ.push_back(16'h0000); mPL = 1; mFull = 1;
          end else mHaveA = 1;
        end else begin
          mPL = sampleLast; mFull = 1; mHaveA = 0;
        end
      end
    end
  end

  task automatic chk(string what, logic [1:0] got, logic [1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%b exp=%b t=%0t", phaseTag, what, got, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("clkBits(R1)", clkBits, mClk);
      chk("frmBits(R2)", frmBits, mFrm);
      chk("lane0(R3)", lane0Bits, mL0);
      chk("lane1(R4)", lane1Bits, mL1);
      chk("ready(R7)", {1'b0, sampleReady}, {1'b0, !mFull});
    end
  end

  always @(negedge clk) bitEn <= gapMode ? ($urandom % 3 != 0) : 1'b1;

  task automatic pushSample(logic [15:0] d, bit last, int gap);
    repeat (gap) @(negedge clk);
    sampleValid = 1'b1; sampleData = d; sampleLast = last;
    forever begin
      bit okNow;
      okNow = sampleReady;
      @(posedge clk);
      @(negedge clk);
      if (okNow) break;
    end
    sampleValid = 1'b0; sampleLast = 1'b0;
  endtask

  task automatic sendBurst(int n, logic [15:0] seed, int gap, int changeAt);
    for (int i = 0; i < n; i++) begin
      if (i == changeAt) begin
        widthSel = 2'd0; ddrMode = ~ddrMode;
      end
      pushSample(seed ^ 16'(i * 16'h1357) ^ 16'h0F0F, i == n - 1, gap);
    end
  endtask

  task automatic settle();
    repeat (120) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phaseTag = "R10";
    chk("reset lane0 R10", lane0Bits, 2'b00);
    chk("reset lane1 R10", lane1Bits, 2'b00);
    chk("reset frm R10", frmBits, 2'b00);
    chk("reset ready R10", {1'b0, sampleReady}, 2'b01);
    chk("reset clk R1", clkBits, 2'b00);
    rst = 1'b0;
    @(negedge clk);

    phaseTag = "R3 ddr16"; ddrMode = 1; widthSel = 2'd2;
    sendBurst(6, 16'hA5C3, 0, -1); settle();

    phaseTag = "R3 ddr12 low bits dropped"; widthSel = 2'd0;
    sendBurst(4, 16'h000F, 0, -1); settle();

    phaseTag = "R4 ddr14 odd count pad"; widthSel = 2'd1;
    sendBurst(5, 16'h7E81, 0, -1); settle();

    phaseTag = "R5 sdr16"; ddrMode = 0; widthSel = 2'd2;
    sendBurst(4, 16'hC001, 0, -1); settle();

    phaseTag = "R5 sdr14 odd"; widthSel = 2'd1;
    sendBurst(3, 16'h3CC3, 0, -1); settle();

    phaseTag = "R8 mid-burst change"; ddrMode = 1; widthSel = 2'd2;
    sendBurst(8, 16'h9669, 0, 3); settle();

    phaseTag = "R9 enable gaps"; ddrMode = 1; widthSel = 2'd1; gapMode = 1;
    sendBurst(6, 16'h5A5A, 0, -1);
    ddrMode = 0; widthSel = 2'd0;
    sendBurst(3, 16'hF00D, 1, -1); settle(); settle();
    gapMode = 0;

    phaseTag = "R6 slow source idle"; ddrMode = 1; widthSel = 2'd2;
    sendBurst(5, 16'h1234, 15, -1); settle();

    phaseTag = "R7 back-to-back bursts"; ddrMode = 1; widthSel = 2'd2;
    sendBurst(4, 16'hBEEF, 0, -1);
    widthSel = 2'd1; ddrMode = 0;
    sendBurst(4, 16'hD00D, 0, -1);
    widthSel = 2'd0; ddrMode = 1;
    sendBurst(3, 16'h4321, 0, -1); settle(); settle();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule